// File: doc/BRIEF.md
# Benes Fabric Control Generator for XOR and Rotate Mappings

This block produces the full set of switch settings for a rearrangeable Benes fabric with N = 2^LOG_N lines, for mappings from one of two families: every item moves from line x to line x XOR k, or every item moves from line x to line (x + k) mod N. A requester supplies the family, the LOG_N-bit constant k and a one-cycle start pulse. The generator then splits the problem into halves, quarters and smaller pieces, one tree level per clock. It needs no permutation table and no general routing pass.

Each level of the split fixes one output-side stage of the fabric. Every node holds its own sub-constant. The low bit of that sub-constant sets every switch of the node's segment in the output-side stage. The upper child then takes the constant shifted right by one. The lower child takes the same value, or in the rotate family that value plus the dropped low bit, wrapped to the child's width. The input-side stages are always straight. The deepest level sets the centre stage.

A small controller with three states drives the walk. IDLE waits for a start. WALK processes one tree depth per cycle. READY holds the finished control word until the next start. There are three transitions: IDLE to WALK on start, WALK to READY after the last depth, and READY to WALK on start. `done_o` is high exactly in READY.

Top module: `benes_ctl_gen`

## Requirements
- R1: After reset, `done_o` is low and every bit of `ctrl_o` is zero.
- R2: `done_o` rises exactly LOG_N clock cycles after the edge that accepts a start. It then stays high, with `ctrl_o` unchanged, until the next accepted start.
- R3: With `fam_i` = 0 (XOR family), the fabric set by `ctrl_o` delivers the item entering line x to output line x XOR k, for every x and every k.
- R4: With `fam_i` = 1 (rotate family), the fabric set by `ctrl_o` delivers the item entering line x to output line (x + k) mod N, for every x and every k, including values where the lower sub-constant wraps.
- R5: When `done_o` is high, every switch in stages 0 to LOG_N-2 is straight (bit value 0).
- R6: When `done_o` is high, every switch in the final stage 2*LOG_N-2 equals bit 0 of the accepted k.
- R7: A start that arrives while the walk is in progress is ignored. The result and its timing belong to the earlier request, and `fam_i` and `k_i` are captured only at the accepting edge.
- R8: A start that arrives while `done_o` is high is accepted, and `done_o` is low on the following cycle.
- R9: Packing and wiring are as follows. Switch p of stage s sits at bit s*(N/2)+p, with 0 meaning straight and 1 meaning crossed. In a sub-fabric of size S that covers segment c at depth d, first-stage switch i (position c*S/2+i, stage d) takes local lines 2i and 2i+1 and feeds upper input i and lower input i. Last-stage switch i (same position, stage 2*LOG_N-2-d) takes upper output i and lower output i and drives local lines 2i and 2i+1. The centre stage LOG_N-1 is a single switch per segment of size 2. Under this packing, XOR with k=1 sets only the final stage, all ones. Rotate with k=1 additionally sets the last N/2^(d+1) switches of stage 2*LOG_N-2-d, and the last switch of the centre stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted in IDLE or READY |
| fam_i | input | 1 | Family select: 0 = XOR with k, 1 = rotate by k |
| k_i | input | LOG_N | Mapping constant |
| ctrl_o | output | (2*LOG_N-1)*2^(LOG_N-1) | Packed switch settings, stage-major |
| done_o | output | 1 | High while the control word is complete and held |

## Verification
Two situations are hard to reach from the ports. The first is the rotate carry into a lower child that wraps, for example k = N-1, where the sub-constant overflows and must be cut back to the child's width. The second is a start that lands while the walk is in progress. The bench drives every k in both families through a behavioural fabric built from the R9 wiring, so every carry pattern occurs. It also issues a second start with a different family and constant one cycle after an accepted start, then checks that the original mapping still comes out on the original schedule.

// File: rtl/benes_ctl_pkg.sv
package benes_ctl_pkg;

    // Mapping family selected by the requester
    typedef enum logic {
        FAM_XOR = 1'b0,
        FAM_ROT = 1'b1
    } fam_e;

    // Walk controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_READY = 2'd2
    } st_e;

endpackage

// File: rtl/benes_ctl_fsm.sv
module benes_ctl_fsm
    import benes_ctl_pkg::*;
#(
    parameter int LOG_N = 4,
    parameter int DW    = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          load_o,
    output logic          step_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] depth_o
);

    localparam logic [DW-1:0] LAST_DEPTH = DW'(LOG_N - 1);

    st_e           st_q;
    st_e           st_nx;
    logic [DW-1:0] depth_q;
    logic          at_last;

    assign at_last = (depth_q == LAST_DEPTH);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // Transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:  if (start_i) st_nx = ST_WALK;
            ST_WALK:  if (at_last) st_nx = ST_READY;
            ST_READY: if (start_i) st_nx = ST_WALK;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // Outputs decoded from the current state
    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        unique case (st_q)
            ST_IDLE:  load_o = start_i;
            ST_WALK: begin
                step_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_READY: begin
                load_o = start_i;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end

    // Tree depth being processed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth_q <= '0;
        end else if (load_o) begin
            depth_q <= '0;
        end else if (step_o && !at_last) begin
            depth_q <= depth_q + 1'b1;
        end
    end

    assign depth_o = depth_q;

endmodule

// File: rtl/benes_ctl_tree.sv
module benes_ctl_tree
    import benes_ctl_pkg::*;
#(
    parameter int LOG_N = 4,
    parameter int DW    = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic                      step_i,
    input  fam_e                      fam_i,
    input  logic [LOG_N-1:0]          k_i,
    input  logic [DW-1:0]             depth_i,
    output logic [(1<<(LOG_N-1))-1:0] row_o
);

    localparam int HALF = 1 << (LOG_N - 1);
    localparam int PW   = (LOG_N > 1) ? LOG_N - 1 : 1;

    fam_e             fam_q;
    logic [PW-1:0]    lane_sel;   // position bit that splits upper and lower child
    logic [LOG_N-1:0] wmask;      // width of a child's sub-constant

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fam_q <= FAM_XOR;
        end else if (load_i) begin
            fam_q <= fam_i;
        end
    end

    always_comb begin
        lane_sel = '0;
        for (int b = 0; b < PW; b++) begin
            if (int'(depth_i) == LOG_N - 2 - b) lane_sel[b] = 1'b1;
        end
        for (int b = 0; b < LOG_N; b++) begin
            wmask[b] = (b < LOG_N - 1 - int'(depth_i));
        end
    end

    // Every position keeps the sub-constant of the node that owns it
    for (genvar p = 0; p < HALF; p++) begin : g_lane
        localparam logic [PW-1:0] POS = PW'(p);

        logic [LOG_N-1:0] kq;
        logic [LOG_N-1:0] half_k;
        logic [LOG_N-1:0] nxt;
        logic             to_lower;

        assign half_k   = {1'b0, kq[LOG_N-1:1]};
        assign to_lower = |(POS & lane_sel);

        always_comb begin
            if (to_lower && fam_q == FAM_ROT) begin
                nxt = (half_k + {{(LOG_N-1){1'b0}}, kq[0]}) & wmask;
            end else begin
                nxt = half_k;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                kq <= '0;
            end else if (load_i) begin
                kq <= k_i;
            end else if (step_i) begin
                kq <= nxt;
            end
        end

        assign row_o[p] = kq[0];
    end

endmodule

// File: rtl/benes_ctl_pack.sv
module benes_ctl_pack #(
    parameter int LOG_N = 4,
    parameter int DW    = (LOG_N > 1) ? $clog2(LOG_N) : 1
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      load_i,
    input  logic                                      step_i,
    input  logic [DW-1:0]                             depth_i,
    input  logic [(1<<(LOG_N-1))-1:0]                 row_i,
    output logic [(2*LOG_N-1)*(1<<(LOG_N-1))-1:0]     ctrl_o
);

    localparam int HALF   = 1 << (LOG_N - 1);
    localparam int STAGES = 2 * LOG_N - 1;

    int tgt;

    // Depth d fixes the output-side stage; the deepest depth fixes the centre
    always_comb begin
        if (int'(depth_i) == LOG_N - 1) begin
            tgt = LOG_N - 1;
        end else begin
            tgt = 2 * LOG_N - 2 - int'(depth_i);
        end
    end

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s < LOG_N - 1) begin : g_fixed
            // input-side stages are always straight for both families
            assign ctrl_o[s*HALF +: HALF] = '0;
        end else begin : g_held
            logic [HALF-1:0] row_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    row_q <= '0;
                end else if (load_i) begin
                    row_q <= '0;
                end else if (step_i && tgt == s) begin
                    row_q <= row_i;
                end
            end
            assign ctrl_o[s*HALF +: HALF] = row_q;
        end
    end

endmodule

// File: rtl/benes_ctl_gen.sv
module benes_ctl_gen
    import benes_ctl_pkg::*;
#(
    parameter int LOG_N = 4
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start_i,
    input  logic                                      fam_i,
    input  logic [LOG_N-1:0]                          k_i,
    output logic [(2*LOG_N-1)*(1<<(LOG_N-1))-1:0]     ctrl_o,
    output logic                                      done_o
);

    localparam int HALF = 1 << (LOG_N - 1);
    localparam int DW   = (LOG_N > 1) ? $clog2(LOG_N) : 1;

    logic            load;
    logic            step;
    logic            walk;
    logic [DW-1:0]   depth;
    logic [HALF-1:0] row;
    fam_e            fam_w;

    assign fam_w = fam_e'(fam_i);

    benes_ctl_fsm #(.LOG_N(LOG_N), .DW(DW)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .busy_o  (walk),
        .done_o  (done_o),
        .depth_o (depth)
    );

    benes_ctl_tree #(.LOG_N(LOG_N), .DW(DW)) u_tree (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .fam_i   (fam_w),
        .k_i     (k_i),
        .depth_i (depth),
        .row_o   (row)
    );

    benes_ctl_pack #(.LOG_N(LOG_N), .DW(DW)) u_pack (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step),
        .depth_i (depth),
        .row_i   (row),
        .ctrl_o  (ctrl_o)
    );

endmodule

// File: rtl/benes_ctl_chk.sv
module benes_ctl_chk #(
    parameter int LOG_N = 4
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic                                  start_i,
    input logic                                  walk_i,
    input logic                                  done_i,
    input logic [(2*LOG_N-1)*(1<<(LOG_N-1))-1:0] ctrl_i
);

    localparam int HALF   = 1 << (LOG_N - 1);
    localparam int STAGES = 2 * LOG_N - 1;
    localparam int CNW    = $clog2(LOG_N + 2);

    logic [CNW-1:0]  cnt;
    logic [HALF-1:0] last_row;

    assign last_row = ctrl_i[(STAGES-1)*HALF +: HALF];

    // cycles since the last accepted start, saturating
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start_i && !walk_i) begin
            cnt <= '0;
        end else if (cnt != CNW'(LOG_N + 1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_i) |-> (cnt == CNW'(LOG_N))); // R2

    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> done_i); // R2

    AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !start_i) |=> $stable(ctrl_i)); // R2

    AST_DONE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && start_i) |=> !done_i); // R8

    AST_LAST_UNIFORM: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> (last_row == '0 || (&last_row))); // R6

endmodule

bind benes_ctl_gen benes_ctl_chk #(.LOG_N(LOG_N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .walk_i  (walk),
    .done_i  (done_o),
    .ctrl_i  (ctrl_o)
);

// File: tb/sim_benes_ctl_gen.sv
module sim_benes_ctl_gen;

    localparam int LOG_N  = 4;
    localparam int N      = 1 << LOG_N;
    localparam int HALF   = N / 2;
    localparam int STAGES = 2 * LOG_N - 1;
    localparam int CW     = STAGES * HALF;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             fam = 1'b0;
    logic [LOG_N-1:0] k = '0;
    logic [CW-1:0]    ctrl;
    logic             done;

    always #4 clk = ~clk; // 125 MHz

    benes_ctl_gen #(.LOG_N(LOG_N)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .fam_i   (fam),
        .k_i     (k),
        .ctrl_o  (ctrl),
        .done_o  (done)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;
    int q_fam[$];
    int q_k[$];
    int q_t[$];
    int lines[N];
    int tmpl[N];
    logic done_d = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int map_of(input int f, input int kk, input int x);
        if (f == 1) return (x + kk) % N;
        return x ^ kk;
    endfunction

    // Behavioural fabric following the R9 wiring; lines[] ends as output order
    task automatic route(input logic [CW-1:0] c);
        for (int x = 0; x < N; x++) lines[x] = x;
        for (int d = 0; d < LOG_N - 1; d++) begin
            int sz = N >> d;
            for (int sg = 0; sg < (1 << d); sg++) begin
                for (int i = 0; i < sz / 2; i++) begin
                    int a = lines[sg*sz + 2*i];
                    int b = lines[sg*sz + 2*i + 1];
                    if (c[d*HALF + sg*(sz/2) + i]) begin
                        tmpl[sg*sz + i] = b;
                        tmpl[sg*sz + sz/2 + i] = a;
                    end else begin
                        tmpl[sg*sz + i] = a;
                        tmpl[sg*sz + sz/2 + i] = b;
                    end
                end
            end
            lines = tmpl;
        end
        for (int sg = 0; sg < HALF; sg++) begin
            if (c[(LOG_N-1)*HALF + sg]) begin
                int a = lines[2*sg];
                lines[2*sg] = lines[2*sg + 1];
                lines[2*sg + 1] = a;
            end
        end
        for (int d = LOG_N - 2; d >= 0; d--) begin
            int sz = N >> d;
            int st = 2*LOG_N - 2 - d;
            for (int sg = 0; sg < (1 << d); sg++) begin
                for (int i = 0; i < sz / 2; i++) begin
                    int u = lines[sg*sz + i];
                    int l = lines[sg*sz + sz/2 + i];
                    if (c[st*HALF + sg*(sz/2) + i]) begin
                        tmpl[sg*sz + 2*i] = l;
                        tmpl[sg*sz + 2*i + 1] = u;
                    end else begin
                        tmpl[sg*sz + 2*i] = u;
                        tmpl[sg*sz + 2*i + 1] = l;
                    end
                end
            end
            lines = tmpl;
        end
    endtask

    // Expected word for rotate by one (R9)
    function automatic logic [CW-1:0] rot1_word();
        logic [CW-1:0] w = '0;
        for (int d = 0; d < LOG_N - 1; d++) begin
            int st = 2*LOG_N - 2 - d;
            for (int p = HALF - (HALF >> d); p < HALF; p++) w[st*HALF + p] = 1'b1;
        end
        w[(LOG_N-1)*HALF + HALF - 1] = 1'b1;
        return w;
    endfunction

    task automatic check_result();
        int f;
        int kk;
        int t0;
        int bad;
        logic [HALF-1:0] last_exp;
        if (q_fam.size() == 0) begin
            chk(1'b0, "R2", "done without a pending request", 1, 0);
            return;
        end
        f  = q_fam.pop_front();
        kk = q_k.pop_front();
        t0 = q_t.pop_front();
        chk(cyc - t0 == LOG_N, "R2", "start-to-done cycles", 64'(cyc - t0), 64'(LOG_N));
        route(ctrl);
        bad = 0;
        for (int x = 0; x < N; x++) begin
            if (lines[map_of(f, kk, x)] != x) bad++;
        end
        chk(bad == 0, (f == 1) ? "R4" : "R3",
            $sformatf("misrouted lines for k=%0d", kk), 64'(bad), 0);
        chk(ctrl[(LOG_N-1)*HALF-1:0] == '0, "R5", "input-side stages",
            64'(ctrl[(LOG_N-1)*HALF-1:0]), 0);
        last_exp = {HALF{kk[0]}};
        chk(ctrl[(STAGES-1)*HALF +: HALF] == last_exp, "R6", "final stage",
            64'(ctrl[(STAGES-1)*HALF +: HALF]), 64'(last_exp));
        if (kk == 1 && f == 0)
            chk(ctrl == {{HALF{1'b1}}, {(CW-HALF){1'b0}}}, "R9", "xor k=1 word",
                64'(ctrl), 64'({{HALF{1'b1}}, {(CW-HALF){1'b0}}}));
        if (kk == 1 && f == 1)
            chk(ctrl == rot1_word(), "R9", "rotate k=1 word", 64'(ctrl), 64'(rot1_word()));
    endtask

    // Monitor: scoreboard pop on each rising done
    always @(negedge clk) begin
        if (rst_n && done && !done_d && !finished) check_result();
        done_d = done;
    end

    // Driver: issue one request and push its expectation
    task automatic issue(input int f, input int kk, input bit poke_busy);
        bit was_done;
        int f0 = fails;
        @(negedge clk);
        was_done = done;
        fam   = f[0];
        k     = kk[LOG_N-1:0];
        start = 1'b1;
        @(posedge clk);
        #1;
        start = 1'b0;
        q_fam.push_back(f);
        q_k.push_back(kk);
        q_t.push_back(cyc);
        if (was_done) chk(done == 1'b0, "R8", "done after restart", 64'(done), 0);
        if (poke_busy) begin
            @(negedge clk);
            start = 1'b1;
            fam   = ~fam;
            k     = k + LOG_N'(3);
            @(negedge clk);
            start = 1'b0;
        end
        while (q_fam.size() != 0) @(negedge clk);
        if (poke_busy) chk(fails == f0, "R7", "start during walk disturbed result",
                           64'(fails - f0), 0);
    endtask

    initial begin
        logic [CW-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0, "R1", "done after reset", 64'(done), 0);
        chk(ctrl == '0, "R1", "ctrl after reset", 64'(ctrl), 0);
        for (int f = 0; f < 2; f++) begin
            for (int kk = 0; kk < N; kk++) issue(f, kk, 1'b0);
        end
        issue(0, 5, 1'b1);
        issue(1, N - 1, 1'b1);
        held = ctrl;
        repeat (6) @(negedge clk);
        chk(done == 1'b1, "R2", "done held while idle", 64'(done), 1);
        chk(ctrl == held, "R2", "ctrl held while idle", 64'(ctrl), 64'(held));
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog expired: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule